// File: doc/BRIEF.md
# Scaled Tick Divider for PWM Clocking

This block turns a base clock-enable tick into a slower scaled tick. It holds an 8-bit scale value and counts base ticks with a down counter. When the counter reaches its terminal count, it produces an internal pulse and reloads from the scale value in the same step. The internal pulses then pass through a divide-by-two stage. The result is one output tick for every `2 * scale` base ticks. A scale value of zero counts as 256.

The output is a single-cycle enable in the system clock domain. It is not a derived clock. A PWM channel can choose it as a slower alternative to the unscaled base tick, and two copies of the block serve two independent clock branches. The scale value is loaded through a plain write strobe with a data bus. A write restarts the division at once, so the new ratio begins from a clean state.

Top module: `pwm_scale_div`

## Requirements
- R1: After reset the scale value is 0 and the output is low. With continuous base ticks, the first output tick follows the 512th base tick.
- R2: The down counter changes only on a base tick or a scale write. Cycles with neither leave the timing of the next output tick unchanged.
- R3: A base tick that finds the counter at 1 produces an internal pulse and reloads the counter from the scale value in that same cycle. No tick is lost between periods.
- R4: Every second internal pulse produces an output tick. The output tick is high in the cycle after the clock edge that sampled the base tick causing that pulse. Output ticks come every `2 * S` base ticks.
- R5: A scale value of 0x00 acts as 256, so the output comes every 512 base ticks.
- R6: A scale value of 1 gives an internal pulse on every base tick, so the output comes every 2 base ticks.
- R7: A scale write takes priority over a base tick in the same cycle, and the base tick in that cycle is ignored. The write loads the new value into the counter, clears the divide-by-two stage and drops any pending output. The first output tick after the write then follows exactly `2 * S` base ticks.
- R8: The output is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Single-cycle base clock enable |
| scale_wr_i | input | 1 | Scale value write strobe |
| scale_data_i | input | 8 | New scale value (0 means 256) |
| scaled_tick_o | output | 1 | Single-cycle scaled clock enable |

## Verification
An output tick is due one clock after the edge that samples the base tick completing the `2 * S`-th count. A scale write shows its effect one clock after the edge that samples it: the output is low and the count restarts. The bench keeps its own behavioural model, which updates at every rising edge from the same sampled inputs. It compares the model against the output at the falling edge, so every result is checked in the cycle it is due. Stimulus covers scale values 0, 1, small and 255. It mixes dense and sparse base ticks, and includes writes that land together with a base tick.

// File: rtl/pwm_scale_pkg.sv
package pwm_scale_pkg;
  localparam int unsigned DEF_SCALE_W = 8;
endpackage

// File: rtl/pwm_scale_reg.sv
module pwm_scale_reg #(
  parameter int unsigned W = pwm_scale_pkg::DEF_SCALE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] scale_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   scale_o <= '0;
    else if (wr_i) scale_o <= data_i;
  end
endmodule

// File: rtl/pwm_scale_count.sv
module pwm_scale_count #(
  parameter int unsigned W = pwm_scale_pkg::DEF_SCALE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] scale_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  // zero wraps to all-ones, giving a full 2**W count
  assign pulse_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (pulse_o) cnt_q <= scale_i;
    else if (tick_i)  cnt_q <= cnt_q - ONE;
  end

  // R2: idle cycles hold the count
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  // R3: terminal tick reloads from scale
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == ONE) |=> (cnt_q == $past(scale_i)));

  // R7: write loads the new value
  p_write_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/pwm_half_stage.sv
module pwm_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic clear_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      tick_o  <= 1'b0;
    end else if (clear_i) begin
      phase_q <= 1'b0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= pulse_i && phase_q;
      if (pulse_i) phase_q <= ~phase_q;
    end
  end

  // R8: single-cycle output
  p_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R7: write drops pending output
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !tick_o);

  // R4: output only from a second pulse
  p_tick_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ($past(pulse_i) && !$past(clear_i)));
endmodule

// File: rtl/pwm_scale_div.sv
module pwm_scale_div #(
  parameter int unsigned SCALE_W = pwm_scale_pkg::DEF_SCALE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_tick_i,
  input  logic               scale_wr_i,
  input  logic [SCALE_W-1:0] scale_data_i,
  output logic               scaled_tick_o
);
  logic [SCALE_W-1:0] scale_q;
  logic               pulse;

  pwm_scale_reg #(.W(SCALE_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (scale_wr_i),
    .data_i (scale_data_i),
    .scale_o(scale_q)
  );

  pwm_scale_count #(.W(SCALE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (base_tick_i),
    .load_i    (scale_wr_i),
    .load_val_i(scale_data_i),
    .scale_i   (scale_q),
    .pulse_o   (pulse)
  );

  pwm_half_stage u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse),
    .clear_i(scale_wr_i),
    .tick_o (scaled_tick_o)
  );
endmodule

// File: tb/pwm_scale_div_bench.sv
module pwm_scale_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tick_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // behavioural model
  int  m_scale = 0;
  int  m_left  = 256;
  bit  m_odd   = 0;
  bit  m_out   = 0;
  bit  prev_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_scale_div u_pwm_scale_div (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_tick_i  (base_tick),
    .scale_wr_i   (wr),
    .scale_data_i (wdata),
    .scaled_tick_o(tick_out)
  );

  function automatic int span(int s);
    return (s == 0) ? 256 : s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scale = 0; m_left = 256; m_odd = 0; m_out = 0;
    end else if (wr) begin
      m_scale = int'(wdata); m_left = span(m_scale); m_odd = 0; m_out = 0;
    end else begin
      m_out = 0;
      if (base_tick) begin
        if (m_left == 1) begin
          m_left = span(m_scale);
          m_out  = m_odd;
          m_odd  = !m_odd;
        end else begin
          m_left = m_left - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (tick_out !== m_out) begin
        fails++;
        $display("FAIL %s: cycle %0d scaled_tick actual=%b expected=%b",
                 cur_req, cycles, tick_out, m_out);
      end
      if (prev_out) begin
        checks++;
        if (tick_out) begin
          fails++;
          $display("FAIL R8: cycle %0d output high twice actual=1 expected=0", cycles);
        end
      end
      prev_out = tick_out;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic run(int n, int density);
    logic [7:0] lfsr = 8'h5a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      base_tick = (density >= 8) ? 1'b1 : (int'(lfsr[2:0]) < density);
      wr = 1'b0;
    end
  endtask

  task automatic write_scale(logic [7:0] v, logic with_tick);
    @(negedge clk);
    wr = 1'b1; wdata = v; base_tick = with_tick;
    @(negedge clk);
    wr = 1'b0; base_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tick_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset output actual=%b expected=0", tick_out);
    end
    rst_n = 1'b1;
    cur_req = "R1 R5";
    run(1100, 8);
    cur_req = "R6";
    write_scale(8'd1, 1'b0);
    run(40, 8);
    cur_req = "R2 R3 R4";
    write_scale(8'd3, 1'b0);
    run(200, 3);
    cur_req = "R7";
    write_scale(8'd5, 1'b1);
    run(60, 8);
    write_scale(8'd2, 1'b1);
    run(9, 8);
    write_scale(8'd4, 1'b0);
    run(50, 5);
    cur_req = "R3 R4";
    write_scale(8'd255, 1'b0);
    run(1200, 8);
    cur_req = "R5 R2";
    write_scale(8'd0, 1'b0);
    run(2500, 4);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule